// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the control slave of a stereo volume stage. It runs on the system clock and oversamples a serial clock, an active-low select and one shared data line. Each transaction carries sixteen serial clocks. The first byte is a command and address, with the most significant bit first. The second byte is the data, also most significant bit first. A write loads a gain or control register. A read turns the data line around, and the slave drives the addressed register back during the second byte.

The data pad is split into an input, an output value and an output enable, so that the tri-state buffer sits outside the block. Each completed write also appears as a one-cycle strobe carrying the register index and the data. The stored gains, the control byte and the mute bit are exported for the analog side.

Top module: `twr_regport`

## Requirements
- R1: After reset all three registers read zero, the mute output is 0, the data output enable is 0 and no write strobe is given.
- R2: A frame with command bit 0 (the first bit) is a write. Serial bits are taken on the rising serial-clock edge. Bits 2..8 form the register index (index 0 = left gain, 1 = right gain, 2 = control) and bits 9..16 form the data. When select rises after exactly 16 rising edges, one single-cycle strobe carries the index and data, and the indexed register takes the data.
- R3: The mute output always equals bit 0 of the control register (index 2).
- R4: A write frame with fewer or more than 16 rising serial-clock edges gives no strobe and changes no register.
- R5: A frame with command bit 1 is a read. The output enable rises after the 8th falling serial-clock edge. The register bits are then presented MSB first, with a new bit after each later falling edge, so bit 7-k is valid before rising edge 9+k.
- R6: In a read, the output enable drops after the 16th falling serial-clock edge, while select is still low.
- R7: Select rising in the middle of a read drops the output enable.
- R8: A write to an index of 3 or above still gives the strobe but changes no register, and a read of such an index returns 0.
- R9: A read frame gives no strobe and changes no register.
- R10: When select rises in the same system-clock cycle as the 8th falling serial-clock edge of a read, select wins and the output enable never asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idle low |
| csn_i | input | 1 | Frame select, active low |
| sdata_i | input | 1 | Data line as seen at the pad |
| sdata_o | output | 1 | Readback bit toward the pad |
| sdata_oe | output | 1 | Pad output enable |
| wr_stb_o | output | 1 | One-cycle strobe for a completed write |
| wr_idx_o | output | 7 | Register index of the write |
| wr_data_o | output | 8 | Data of the write |
| gain_l_o | output | 8 | Left gain code |
| gain_r_o | output | 8 | Right gain code |
| ctrl_o | output | 8 | Control byte |
| mute_o | output | 1 | Software mute (control bit 0) |

## Verification
The end of a frame (select rising) and a serial-clock falling edge can be detected in the same system cycle. When this happens at the turnaround point of a read, the block must choose between enabling the pad and closing the frame. The bench provokes this by dropping the serial clock and raising select in the same cycle after the eighth bit of a read. It then judges the result by counting the cycles in which the output enable is high, which must be zero. Random writes, reads, short frames and long frames are mixed with this case, and each one is checked against a register model kept in the bench.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int REG_LGAIN = 0;
  localparam int REG_RGAIN = 1;
  localparam int REG_CTRL  = 2;
  localparam int MUTE_BIT  = 0;
  localparam int NUM_REGS  = 3;
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_dly
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[b];
        s2 <= RST_VAL[b];
        s3 <= RST_VAL[b];
      end else begin
        s1 <= d[b];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign q[b]     = s2;
    assign q_dly[b] = s3;
  end
endmodule

// File: rtl/twr_regfile.sv
module twr_regfile #(
  parameter int DW   = 8,
  parameter int IW   = 7,
  parameter int NREG = twr_pkg::NUM_REGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [IW-1:0]    wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IW-1:0]    rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic [NREG*DW-1:0] regs_flat
);
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic wen;
    assign wen = wr_stb && (wr_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[i] <= '0;
      else if (wen) regs[i] <= wr_data;
    end
    assign regs_flat[i*DW +: DW] = regs[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IW'(i)) rd_data = regs[i];
  end
endmodule

// File: rtl/twr_frame.sv
module twr_frame #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int FB = AW + DW,
  localparam int CW = $clog2(FB + 2),
  localparam int IW = AW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          sclk_d,
  input  logic          csn_s,
  input  logic          csn_d,
  input  logic          sdi_s,
  input  logic [DW-1:0] rd_data,
  output logic [IW-1:0] rd_idx,
  output logic          sdo,
  output logic          oe,
  output logic          wr_stb,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_data
);
  logic sclk_rise, sclk_fall, cs_start, cs_end, active;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [FB-1:0] sh_q, sh_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] osh_q, osh_n;
  logic          oe_q, oe_n, stb_q, stb_n;
  logic [IW-1:0] widx_q, widx_n;
  logic [DW-1:0] wdat_q, wdat_n;
  logic          is_read;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_start  = ~csn_s & csn_d;
  assign cs_end    = csn_s & ~csn_d;
  assign active    = ~csn_s;
  assign is_read   = addr_q[AW-1];

  always_comb begin
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    addr_n = addr_q;
    osh_n  = osh_q;
    oe_n   = oe_q;
    stb_n  = 1'b0;
    widx_n = widx_q;
    wdat_n = wdat_q;
    if (cs_start) begin
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (cs_end) begin
      oe_n = 1'b0;
      if (cnt_q == CW'(FB) && !is_read) begin
        stb_n  = 1'b1;
        widx_n = addr_q[IW-1:0];
        wdat_n = sh_q[DW-1:0];
      end
    end else if (active) begin
      if (sclk_rise && cnt_q <= CW'(FB)) begin
        cnt_n = cnt_q + 1'b1;
        sh_n  = {sh_q[FB-2:0], sdi_s};
        if (cnt_q == CW'(AW - 1)) addr_n = {sh_q[AW-2:0], sdi_s};
      end
      if (sclk_fall) begin
        if (cnt_q == CW'(AW) && is_read) begin
          oe_n  = 1'b1;
          osh_n = rd_data;
        end else if (oe_q && cnt_q > CW'(AW) && cnt_q < CW'(FB)) begin
          osh_n = {osh_q[DW-2:0], 1'b0};
        end else if (cnt_q >= CW'(FB)) begin
          oe_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      addr_q <= '0;
      osh_q  <= '0;
      oe_q   <= 1'b0;
      stb_q  <= 1'b0;
      widx_q <= '0;
      wdat_q <= '0;
    end else begin
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      addr_q <= addr_n;
      osh_q  <= osh_n;
      oe_q   <= oe_n;
      stb_q  <= stb_n;
      widx_q <= widx_n;
      wdat_q <= wdat_n;
    end
  end

  assign rd_idx  = addr_q[IW-1:0];
  assign sdo     = osh_q[DW-1];
  assign oe      = oe_q;
  assign wr_stb  = stb_q;
  assign wr_idx  = widx_q;
  assign wr_data = wdat_q;
endmodule

// File: rtl/twr_regport.sv
module twr_regport #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int IW = AW - 1,
  localparam int NR = twr_pkg::NUM_REGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic          csn_i,
  input  logic          sdata_i,
  output logic          sdata_o,
  output logic          sdata_oe,
  output logic          wr_stb_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [DW-1:0] wr_data_o,
  output logic [DW-1:0] gain_l_o,
  output logic [DW-1:0] gain_r_o,
  output logic [DW-1:0] ctrl_o,
  output logic          mute_o
);
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [2:0] pin_s, pin_d;
  logic       csn_s;
  twr_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .d({sdata_i, csn_i, sclk_i}), .q(pin_s), .q_dly(pin_d)
  );
  assign csn_s = pin_s[1];

  logic [IW-1:0]    rd_idx;
  logic [DW-1:0]    rd_data;
  logic [NR*DW-1:0] regs_flat;

  twr_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_sync_n),
    .sclk_s(pin_s[0]), .sclk_d(pin_d[0]),
    .csn_s(pin_s[1]), .csn_d(pin_d[1]),
    .sdi_s(pin_s[2]), .rd_data(rd_data), .rd_idx(rd_idx),
    .sdo(sdata_o), .oe(sdata_oe),
    .wr_stb(wr_stb_o), .wr_idx(wr_idx_o), .wr_data(wr_data_o)
  );

  twr_regfile #(.DW(DW), .IW(IW), .NREG(NR)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_stb(wr_stb_o), .wr_idx(wr_idx_o), .wr_data(wr_data_o),
    .rd_idx(rd_idx), .rd_data(rd_data), .regs_flat(regs_flat)
  );

  assign gain_l_o = regs_flat[twr_pkg::REG_LGAIN*DW +: DW];
  assign gain_r_o = regs_flat[twr_pkg::REG_RGAIN*DW +: DW];
  assign ctrl_o   = regs_flat[twr_pkg::REG_CTRL*DW +: DW];
  assign mute_o   = ctrl_o[twr_pkg::MUTE_BIT];
endmodule

// File: rtl/twr_checker.sv
module twr_checker #(
  parameter int IW = 7,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csn_hi,
  input logic          sdata_oe,
  input logic          wr_stb,
  input logic [IW-1:0] wr_idx,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] gain_l,
  input logic [DW-1:0] gain_r,
  input logic [DW-1:0] ctrl
);
  assert_stb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_stb_after_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (csn_hi && $past(csn_hi)));
  assert_left_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_idx == IW'(0)) |=> gain_l == $past(wr_data));
  assert_ctrl_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_idx == IW'(2)) |=> ctrl == $past(wr_data));
  assert_regs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb || wr_idx > IW'(2)) |=> ($stable(gain_l) && $stable(gain_r) && $stable(ctrl)));
  assert_oe_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csn_hi) |=> !sdata_oe);
  assert_oe_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe |-> !$past(csn_hi));
endmodule

bind twr_regport twr_checker #(.IW(IW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .csn_hi(csn_s), .sdata_oe(sdata_oe),
  .wr_stb(wr_stb_o), .wr_idx(wr_idx_o), .wr_data(wr_data_o),
  .gain_l(gain_l_o), .gain_r(gain_r_o), .ctrl(ctrl_o)
);

// File: tb/twr_regport_tb.sv
module twr_regport_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n, sclk, csn, sdi;
  logic sdata_o, sdata_oe, wr_stb;
  logic [6:0] wr_idx;
  logic [7:0] wr_data, gain_l, gain_r, ctrl;
  logic mute;

  twr_regport u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdata_i(sdi),
    .sdata_o(sdata_o), .sdata_oe(sdata_oe), .wr_stb_o(wr_stb),
    .wr_idx_o(wr_idx), .wr_data_o(wr_data), .gain_l_o(gain_l),
    .gain_r_o(gain_r), .ctrl_o(ctrl), .mute_o(mute)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, stb_cnt = 0, oe_cycles = 0;
  logic [6:0] stb_idx;
  logic [7:0] stb_data;
  logic [7:0] mreg [3];
  bit done = 0;

  always @(negedge clk) if (rst_n) begin
    if (wr_stb) begin stb_cnt++; stb_idx = wr_idx; stb_data = wr_data; end
    if (sdata_oe) oe_cycles++;
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_read(int idx);
    return (idx < 3) ? mreg[idx] : 8'h00;
  endfunction

  task automatic run_frame(input logic [7:0] a, input logic [7:0] d, input int nbits,
                           input bit cs_with_fall, output logic [7:0] rd, output logic oe_end);
    rd = '0;
    csn = 1'b0;
    wait_cyc(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 8) ? a[7-i] : ((i < 16) ? d[15-i] : 1'b0);
      wait_cyc(HALF);
      if (i >= 8 && i < 16) rd[15-i] = sdata_o;
      sclk = 1'b1;
      wait_cyc(HALF);
      sclk = 1'b0;
      if (cs_with_fall && i == nbits - 1) csn = 1'b1;
    end
    wait_cyc(HALF);
    oe_end = sdata_oe;
    csn = 1'b1;
    wait_cyc(HALF);
  endtask

  task automatic check_regs(string req);
    chk({req, " left"},  gain_l, mreg[0]);
    chk({req, " right"}, gain_r, mreg[1]);
    chk({req, " ctrl"},  ctrl,   mreg[2]);
    chk("R3 mute", mute, mreg[2][0]);
  endtask

  task automatic do_write(int idx, logic [7:0] d, int nbits);
    int pre;
    logic [7:0] rd;
    logic oe_end;
    pre = stb_cnt;
    run_frame({1'b0, 7'(idx)}, d, nbits, 1'b0, rd, oe_end);
    if (nbits == 16) begin
      chk("R2 strobe count", stb_cnt, pre + 1);
      chk("R2 strobe index", stb_idx, idx);
      chk("R2 strobe data",  stb_data, d);
      if (idx < 3) mreg[idx] = d;
      check_regs(idx < 3 ? "R2" : "R8");
    end else begin
      chk("R4 no strobe", stb_cnt, pre);
      check_regs("R4");
    end
  endtask

  task automatic do_read(int idx);
    int pre;
    logic [7:0] rd;
    logic oe_end;
    pre = stb_cnt;
    oe_cycles = 0;
    run_frame({1'b1, 7'(idx)}, 8'($urandom), 16, 1'b0, rd, oe_end);
    chk(idx < 3 ? "R5 read data" : "R8 read unknown", rd, exp_read(idx));
    chk("R6 oe released before end", oe_end, 0);
    chk("R5 oe duration", (oe_cycles >= 15*HALF) ? 1 : 0, 1);
    chk("R9 no strobe on read", stb_cnt, pre);
    check_regs("R9");
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; sdi = 1'b0;
    for (int i = 0; i < 3; i++) mreg[i] = 8'h00;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(6);
    chk("R1 oe", sdata_oe, 0);
    chk("R1 strobe", wr_stb, 0);
    check_regs("R1");

    do_write(0, 8'hA5, 16);
    do_write(1, 8'h3C, 16);
    do_write(2, 8'h01, 16);
    do_read(0);
    do_read(2);
    do_write(5, 8'hFF, 16);
    do_read(5);
    do_write(1, 8'h77, 12);
    do_write(0, 8'h11, 17);

    begin
      logic [7:0] rd;
      logic oe_end;
      run_frame({1'b1, 7'd1}, 8'h00, 12, 1'b0, rd, oe_end);
      chk("R7 oe on mid-frame", oe_end, 1);
      chk("R5 partial read", rd[7:4], mreg[1][7:4]);
      chk("R7 oe after select rise", sdata_oe, 0);
      oe_cycles = 0;
      run_frame({1'b1, 7'd0}, 8'h00, 8, 1'b1, rd, oe_end);
      chk("R10 oe never asserted", oe_cycles, 0);
    end

    for (int n = 0; n < 50; n++) begin
      int kind;
      kind = $urandom_range(0, 4);
      case (kind)
        0, 1: do_write($urandom_range(0, 2), 8'($urandom), 16);
        2:    do_read($urandom_range(0, 3));
        3:    do_write($urandom_range(0, 2), 8'($urandom), $urandom_range(1, 15));
        default: do_write($urandom_range(3, 127), 8'($urandom), 16);
      endcase
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule